// File: doc/BRIEF.md
# Linked-list DMA descriptor engine

This block is a single-channel DMA mover whose channel setup comes from a chain of descriptors held in memory rather than from software writes between buffers. Software writes the address of the first descriptor into a pointer register and then writes a 1 to the start bit. From then on the engine repeats a loop with no further software action. It reads a five-word descriptor through its memory master port, loads the live channel registers, copies the buffer from source to destination, marks the descriptor complete in memory, and follows the next-descriptor pointer.

A single word-wide valid/ready master port carries every access: descriptor reads, source reads, destination writes and write-backs. Byte enables place byte and halfword beats on their little-endian lanes. An internal packing buffer lets the source and destination widths differ. When a descriptor whose stop bit is set has been written back, the channel becomes free again and a sticky completion flag is raised. Software clears that flag with a status read.

Top module: `dma_chain_engine`

## Requirements
- R1: While reset is held and after it is released, busy, chain_done and mem_req are all 0.
- R2: A write to selector 1 starts the chain only when bit 0 of the written data is 1. Writing 0 there leaves busy at 0 and issues no memory request.
- R3: The engine fetches a descriptor as five word reads, in this order, at base +0, +4, +8, +12 and +16: source address, destination address, next pointer, control A, control B. The first base is the pointer register value at the moment of the start write.
- R4: Control A bits [17:16] set the source width and bits [21:20] set the destination width, encoded 0 = byte, 1 = halfword, 2 = word. Each beat uses lane addr[1:0] of a little-endian word, and mem_be marks exactly the bytes of that beat.
- R5: Control B bits [1:0] set the source address mode and bits [5:4] set the destination address mode, encoded 0 = increment, 1 = decrement, 2 or 3 = fixed. After each beat the address moves by that side's width in bytes.
- R6: Control A bits [15:0] give the buffer length in source-width units. The bytes read are written to the destination in the order they were read, repacked to the destination width. Software keeps the byte total a multiple of the destination width.
- R7: After the last data beat of a buffer, the engine writes control A with bit 31 set back to base +12 of that descriptor, and does so before any later fetch.
- R8: When control B bit 8 is clear, the next fetch starts at the next-pointer word. When it is set, the chain ends after the write-back.
- R9: At the end of a chain, busy falls and chain_done rises on the same edge. chain_done stays set until a stat_rd pulse clears it on the next edge.
- R10: A pointer write (selector 0) while busy is ignored, so a later start uses the previously held pointer.
- R11: While mem_req is high and mem_ready is low, the request (address, write flag, data, byte enables) stays unchanged. Each accepted beat is performed exactly once, whatever the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = descriptor pointer, 1 = start bit |
| cfg_wdata | input | ADDR_W | Register write data |
| stat_rd | input | 1 | Status read pulse; clears chain_done |
| busy | output | 1 | Channel is running a chain |
| chain_done | output | 1 | Sticky chain-complete flag |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_be | output | 4 | Byte enables of the beat |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
The start write is sampled on one edge, and the first descriptor read is requested in the cycle that follows. A beat completes on the edge where mem_req and mem_ready are both high. busy falls and chain_done rises on the edge that accepts the write-back of the stop descriptor. A stat_rd pulse clears the flag on the next edge. The bench drives every input and reads every output at the falling edge. It waits for chain_done and only then compares memory, the logged access order and the access count with its own model of the chain. It checks the flag a full cycle after stat_rd.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;

  // control word A field positions
  localparam int CA_SW_LSB = 16;
  localparam int CA_DW_LSB = 20;
  localparam int CA_DONE   = 31;
  // control word B field positions
  localparam int CB_SM_LSB = 0;
  localparam int CB_DM_LSB = 4;
  localparam int CB_STOP   = 8;

  // descriptor word offsets
  localparam int OFS_CTLA = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2,
    ST_WB    = 2'd3
  } dma_state_e;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2
  } addr_mode_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        mode,
  input  logic [2:0]        nbytes,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] delta;

  assign delta = ADDR_W'(nbytes);

  always_comb begin
    case (mode)
      2'd0:    nxt_addr = cur_addr + delta;
      2'd1:    nxt_addr = cur_addr - delta;
      default: nxt_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             push,
  input  logic [2:0]       push_n,
  input  logic [31:0]      push_data,
  input  logic             pop,
  input  logic [2:0]       pop_n,
  output logic [CNT_W-1:0] cnt,
  output logic [31:0]      head
);
  logic [DEPTH*8-1:0] data_q, data_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               upd;

  assign upd = clr | push | pop;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr) begin
      data_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop) begin
        data_d = data_d >> (8 * int'(pop_n));
        cnt_d  = cnt_d - CNT_W'(pop_n);
      end
      if (push) begin
        for (int i = 0; i < 4; i++) begin
          if ((i < int'(push_n)) && ((int'(cnt_d) + i) < DEPTH)) begin
            data_d[(int'(cnt_d) + i)*8 +: 8] = push_data[i*8 +: 8];
          end
        end
        cnt_d = cnt_d + CNT_W'(push_n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign head = data_q[31:0];

  // R6: packing never drops or invents bytes
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && !pop && !clr) |-> (int'(cnt_q) + int'(push_n) <= DEPTH));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop && !clr) |-> (int'(cnt_q) >= int'(pop_n)));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 8,
  localparam int BCNT_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              stat_rd,
  output logic              busy,
  output logic              chain_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // ---------------- state ----------------
  dma_state_e        state_q, state_d;
  logic [2:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] dptr_q, dptr_d;
  logic [ADDR_W-1:0] desc_q, desc_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [ADDR_W-1:0] next_q, next_d;
  logic [31:0]       ctla_q, ctla_d;
  logic [1:0]        smode_q, smode_d;
  logic [1:0]        dmode_q, dmode_d;
  logic              stop_q, stop_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              done_q, done_d;

  // ---------------- datapath helpers ----------------
  logic [2:0]        sbytes, dbytes;
  logic [ADDR_W-1:0] src_nxt, dst_nxt;
  logic [BCNT_W-1:0] buf_cnt;
  logic [31:0]       buf_head;
  logic              do_wr, do_rd, mv_end, fire;
  logic              buf_push, buf_pop, buf_clr;
  logic [31:0]       rd_aligned;

  assign sbytes = width_bytes(ctla_q[CA_SW_LSB +: 2]);
  assign dbytes = width_bytes(ctla_q[CA_DW_LSB +: 2]);

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .cur_addr (src_q),
    .mode     (smode_q),
    .nbytes   (sbytes),
    .nxt_addr (src_nxt)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .cur_addr (dst_q),
    .mode     (dmode_q),
    .nbytes   (dbytes),
    .nxt_addr (dst_nxt)
  );

  // writes drain first so the buffer always has room for a source beat
  assign do_wr  = (state_q == ST_MOVE) && (buf_cnt >= BCNT_W'(dbytes));
  assign do_rd  = (state_q == ST_MOVE) && !do_wr && (remain_q != '0);
  assign mv_end = (state_q == ST_MOVE) && !do_wr && (remain_q == '0);

  assign mem_req = (state_q == ST_FETCH) || (state_q == ST_WB) || do_rd || do_wr;
  assign fire    = mem_req && mem_ready;

  assign rd_aligned = mem_rdata >> {src_q[1:0], 3'b000};
  assign buf_push   = do_rd && fire;
  assign buf_pop    = do_wr && fire;
  assign buf_clr    = (state_q == ST_IDLE) || mv_end;

  dma_pack_buf #(.DEPTH(BUF_BYTES)) u_pack (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr       (buf_clr),
    .push      (buf_push),
    .push_n    (sbytes),
    .push_data (rd_aligned),
    .pop       (buf_pop),
    .pop_n     (dbytes),
    .cnt       (buf_cnt),
    .head      (buf_head)
  );

  // ---------------- memory request outputs ----------------
  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 4'b0000;
    case (state_q)
      ST_FETCH: begin
        mem_addr = desc_q + ADDR_W'({idx_q, 2'b00});
        mem_be   = 4'b1111;
      end
      ST_WB: begin
        mem_we    = 1'b1;
        mem_addr  = desc_q + ADDR_W'(OFS_CTLA);
        mem_wdata = ctla_q | (32'd1 << CA_DONE);
        mem_be    = 4'b1111;
      end
      ST_MOVE: begin
        if (do_wr) begin
          mem_we    = 1'b1;
          mem_addr  = dst_q;
          mem_wdata = buf_head << {dst_q[1:0], 3'b000};
          mem_be    = lane_mask(dbytes) << dst_q[1:0];
        end else if (do_rd) begin
          mem_addr = src_q;
          mem_be   = lane_mask(sbytes) << src_q[1:0];
        end
      end
      default: ;
    endcase
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    dptr_d   = dptr_q;
    desc_d   = desc_q;
    src_d    = src_q;
    dst_d    = dst_q;
    next_d   = next_q;
    ctla_d   = ctla_q;
    smode_d  = smode_q;
    dmode_d  = dmode_q;
    stop_d   = stop_q;
    remain_d = remain_q;
    done_d   = done_q;

    if (stat_rd) done_d = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (cfg_we && !cfg_sel) dptr_d = cfg_wdata;
        if (cfg_we && cfg_sel && cfg_wdata[0]) begin
          desc_d  = dptr_q;
          idx_d   = 3'd0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fire) begin
          idx_d = idx_q + 3'd1;
          case (idx_q)
            3'd0: src_d  = ADDR_W'(mem_rdata);
            3'd1: dst_d  = ADDR_W'(mem_rdata);
            3'd2: next_d = ADDR_W'(mem_rdata);
            3'd3: begin
              ctla_d   = mem_rdata;
              remain_d = mem_rdata[LEN_W-1:0];
            end
            default: begin
              smode_d = mem_rdata[CB_SM_LSB +: 2];
              dmode_d = mem_rdata[CB_DM_LSB +: 2];
              stop_d  = mem_rdata[CB_STOP];
              state_d = ST_MOVE;
            end
          endcase
        end
      end
      ST_MOVE: begin
        if (buf_push) begin
          src_d    = src_nxt;
          remain_d = remain_q - LEN_W'(1);
        end
        if (buf_pop) dst_d = dst_nxt;
        if (mv_end) state_d = ST_WB;
      end
      ST_WB: begin
        if (fire) begin
          if (stop_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            desc_d  = next_q;
            idx_d   = 3'd0;
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  logic en_ctl, en_ptr;
  assign en_ctl = (state_q != ST_IDLE) || (cfg_we && cfg_sel);
  assign en_ptr = (state_q == ST_IDLE) && cfg_we && !cfg_sel;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      desc_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      next_q  <= '0;
      ctla_q  <= '0;
      smode_q <= '0;
      dmode_q <= '0;
      stop_q  <= 1'b0;
      remain_q <= '0;
    end else if (en_ctl) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      desc_q  <= desc_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      next_q  <= next_d;
      ctla_q  <= ctla_d;
      smode_q <= smode_d;
      dmode_q <= dmode_d;
      stop_q  <= stop_d;
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     dptr_q <= '0;
    else if (en_ptr) dptr_q <= dptr_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign busy       = (state_q != ST_IDLE);
  assign chain_done = done_q;

  // ---------------- assertions ----------------
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_be)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !mem_req);

  p_end_flag_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> chain_done);

  p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(dptr_q));

  p_fetch_read_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> (!mem_we && (mem_addr[1:0] == 2'b00)));

  p_be_lanes_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> ($countones(mem_be) != 0));
endmodule

// File: tb/dma_chain_engine_tb_top.sv
module dma_chain_engine_tb_top;
  localparam int MEM_WORDS = 1024;
  localparam int LOG_N     = 4096;

  logic        clk, rst_n;
  logic        cfg_we, cfg_sel, stat_rd;
  logic [31:0] cfg_wdata;
  logic        busy, chain_done;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem     [MEM_WORDS];
  logic [31:0] exp_mem [MEM_WORDS];
  logic [31:0] log_addr [LOG_N];
  logic        log_we   [LOG_N];
  int          log_n;
  bit          stall_on;

  int errs, checks;
  int ch_d [8];
  int ch_nx[8];
  int ch_cnt;

  dma_chain_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .busy(busy),
    .chain_done(chain_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  assign mem_rdata = mem[mem_addr[11:2]];

  always @(negedge clk) mem_ready <= stall_on ? (($urandom % 3) != 0) : 1'b1;

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      if (log_n < LOG_N) begin
        log_addr[log_n] <= mem_addr;
        log_we[log_n]   <= mem_we;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] eb(input int a);
    return exp_mem[a >> 2][(a & 3)*8 +: 8];
  endfunction

  task automatic ew(input int a, input logic [7:0] v);
    exp_mem[a >> 2][(a & 3)*8 +: 8] = v;
  endtask

  function automatic int wbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic int stepa(input int a, input logic [1:0] m, input int n);
    return (m == 2'd0) ? a + n : (m == 2'd1) ? a - n : a;
  endfunction

  // reference model of a whole chain on exp_mem; returns expected beat count
  task automatic model_chain(input int ptr, output int nacc);
    int d, sa, da, n, sb, db, nb;
    logic [31:0] ca, cb;
    logic [7:0] bytes [256];
    nacc = 0; ch_cnt = 0; d = ptr;
    forever begin
      sa = exp_mem[d >> 2]; da = exp_mem[(d >> 2) + 1];
      ca = exp_mem[(d >> 2) + 3]; cb = exp_mem[(d >> 2) + 4];
      ch_d[ch_cnt] = d; ch_nx[ch_cnt] = exp_mem[(d >> 2) + 2];
      sb = wbytes(ca[17:16]); db = wbytes(ca[21:20]); n = ca[15:0]; nb = 0;
      for (int i = 0; i < n; i++) begin
        for (int k = 0; k < sb; k++) begin bytes[nb] = eb(sa + k); nb++; end
        sa = stepa(sa, cb[1:0], sb);
      end
      for (int j = 0; j < nb / db; j++) begin
        for (int k = 0; k < db; k++) ew(da + k, bytes[j*db + k]);
        da = stepa(da, cb[5:4], db);
      end
      exp_mem[(d >> 2) + 3] = ca | 32'h8000_0000;
      nacc += 5 + n + nb / db + 1;
      ch_cnt++;
      if (cb[8]) break;
      d = ch_nx[ch_cnt - 1];
    end
  endtask

  task automatic put_desc(input int d, input int sa, input int da, input int nx,
                          input int len, input int sw, input int dw,
                          input int sm, input int dm, input bit stop);
    logic [31:0] w [5];
    w[0] = sa; w[1] = da; w[2] = nx;
    w[3] = (len & 16'hFFFF) | (sw << 16) | (dw << 20);
    w[4] = (sm & 3) | ((dm & 3) << 4) | (32'(stop) << 8);
    for (int i = 0; i < 5; i++) begin
      mem[(d >> 2) + i] = w[i];
      exp_mem[(d >> 2) + i] = w[i];
    end
  endtask

  task automatic fill_data();
    for (int i = 64; i < MEM_WORDS; i++) begin
      mem[i] = $urandom;
      exp_mem[i] = mem[i];
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic status_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic run_chain(input int ptr, input bit set_ptr, input bit poke,
                           input string tag);
    int start, nacc, t, bad, first_bad, wi;
    bit ok;
    model_chain(ptr, nacc);
    start = log_n;
    if (set_ptr) cfg_write(1'b0, ptr);
    cfg_write(1'b1, 32'h1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_write(1'b0, 32'h0000_00F0);
    end
    t = 0;
    while (!chain_done && t < 20000) begin @(negedge clk); t++; end
    // R9: flag up and channel free after the last write-back
    chk(chain_done && !busy, "R9", {tag, " end state"},
        {30'd0, busy, chain_done}, 32'h1);
    @(negedge clk);
    // R3 (and R10 when the pointer was poked): fetch order from the held pointer
    ok = 1;
    for (int k = 0; k < 5; k++)
      if (log_addr[start + k] != 32'(ptr + 4*k) || log_we[start + k]) ok = 0;
    chk(ok, poke ? "R10" : "R3", {tag, " first fetch"}, log_addr[start], ptr);
    // R11: every beat once
    chk(log_n - start == nacc, "R11", {tag, " beat count"}, log_n - start, nacc);
    // R4 R5 R6: memory image
    bad = 0; first_bad = -1;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R4/R5/R6", {tag, " memory image"},
        (first_bad < 0) ? 0 : mem[first_bad], (first_bad < 0) ? 0 : exp_mem[first_bad]);
    // R7 R8: write-back precedes the next fetch
    ok = 1; wi = start;
    for (int j = 0; j < ch_cnt; j++) begin
      while (wi < log_n && !(log_we[wi] && log_addr[wi] == 32'(ch_d[j] + 12))) wi++;
      if (wi >= log_n) ok = 0;
      else if (j < ch_cnt - 1) begin
        if (log_addr[wi + 1] != 32'(ch_nx[j]) || log_we[wi + 1]) ok = 0;
      end else if (wi != log_n - 1) ok = 0;
      wi++;
    end
    chk(ok, "R7/R8", {tag, " write-back order"}, wi, ch_cnt);
  endtask

  initial begin
    int len, sw, dw, sm, dm, nd, d, sa, da;
    void'($urandom(32'd20240611));
    errs = 0; checks = 0; log_n = 0; stall_on = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; stat_rd = 0;
    for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !chain_done && !mem_req, "R1", "in reset",
        {29'd0, busy, chain_done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !chain_done && !mem_req, "R1", "after reset",
        {29'd0, busy, chain_done, mem_req}, 0);

    // R2: start bit written as 0
    cfg_write(1'b0, 32'h40);
    cfg_write(1'b1, 32'h0);
    repeat (10) @(negedge clk);
    chk(!busy && log_n == 0, "R2", "zero start bit", {31'd0, busy}, 0);

    // directed: word->byte inc/inc, byte->word dec/fixed, empty stop descriptor
    fill_data();
    put_desc(32'h40, 32'h400, 32'hA00, 32'hC0, 4, 2, 0, 0, 0, 0);
    put_desc(32'hC0, 32'h700, 32'hC00, 32'h80, 8, 0, 2, 1, 2, 0);
    put_desc(32'h80, 32'h800, 32'hE00, 32'h0,  0, 1, 1, 0, 0, 1);
    run_chain(32'h40, 1, 0, "directed");

    // R9: sticky until a status read
    repeat (5) @(negedge clk);
    chk(chain_done, "R9", "flag sticky", {31'd0, chain_done}, 1);
    status_read();
    chk(!chain_done, "R9", "flag cleared by read", {31'd0, chain_done}, 0);

    // halfword source to word destination with decrementing destination
    fill_data();
    put_desc(32'h20, 32'h402, 32'hB00, 32'h0, 6, 1, 2, 0, 1, 1);
    stall_on = 1;
    run_chain(32'h20, 1, 0, "half-to-word");
    status_read();

    // R10: pointer poked while busy; rerun without a new pointer write
    fill_data();
    put_desc(32'h60, 32'h500, 32'hA40, 32'h0, 12, 0, 1, 0, 0, 1);
    run_chain(32'h60, 1, 1, "poke");
    status_read();
    run_chain(32'h60, 0, 0, "rerun");
    status_read();
    chk(1'b1 && log_addr[log_n - 1] == 32'h6C, "R10", "rerun from held pointer",
        log_addr[log_n - 1], 32'h6C);

    // constrained random chains with stalls
    for (int sc = 0; sc < 12; sc++) begin
      fill_data();
      nd = 1 + ($urandom % 3);
      for (int i = 0; i < nd; i++) begin
        sw = $urandom % 3; dw = $urandom % 3; sm = $urandom % 4; dm = $urandom % 4;
        len = (1 + ($urandom % 8)) * ((dw > sw) ? (1 << (dw - sw)) : 1);
        d  = 32'hC0 - 32'h30 * i;
        sa = 32'h400 + 32'h200 * i + ((sm == 1) ? 32'h100 : 0);
        da = 32'hA00 + 32'h200 * i + ((dm == 1) ? 32'h100 : 0);
        put_desc(d, sa, da, 32'hC0 - 32'h30 * (i + 1), len, sw, dw, sm, dm, i == nd - 1);
      end
      run_chain(32'hC0, 1, 0, "random");
      status_read();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule